// File: doc/BRIEF.md
# Turn-Signal Flasher Controller

This block sequences a single direction-indicator lamp output. When the driver's selector closes, the controller waits for a settling interval. It then toggles a lamp-drive enable with a fixed 50 percent duty cycle at the normal flash rate. Each ON phase has a fixed diagnosis instant. At that instant a digital underload flag, produced by an external current comparator, is sampled. A missing lamp cuts the ON phase short and moves the controller to a faster failure rate, so the driver sees the fault as quicker flashing. While the failure rate is active, every later ON phase samples the flag again, and a repaired lamp returns the controller to the normal rate.

The controller also reacts to the power stage's protection flags. An overtemperature or short-circuit flag during an ON phase switches the drive off until both flags clear, after which the ON phase starts again. These restarts are allowed only inside a bounded retry window that begins at the first trip. If a trip is still present or recurs after the window has run out, the drive latches off. A short that is present exactly at the diagnosis instant latches at once. Opening the selector clears the latch, and the next closing starts a fresh initialisation. All intervals are counted in ticks from a prescaler, and the normal and failure half-periods are separate reload parameters.

Top module: `turn_flasher`

## Requirements
- R1: After reset, and on the clock edge after `selEngaged` goes low from any state, `lampDrive` and `faultStatus` are 0. A release also clears the failure-rate mode and the latch.
- R2: `lampDrive` first rises only after `selEngaged` has stayed high for INIT_TICKS prescaler ticks. Measured from the cycle in which the selector closes, the delay lies between (INIT_TICKS-1)*TICK_DIV+2 and INIT_TICKS*TICK_DIV+1 clock cycles.
- R3: With no flags raised, every ON phase and every OFF phase lasts exactly NORM_HALF*TICK_DIV clock cycles.
- R4: If `underloadFlag` is 1 at the diagnosis tick (DIAG_TICKS ticks into an ON phase) while the normal rate is active, the drive falls at that tick, so the ON phase lasts DIAG_TICKS*TICK_DIV cycles, and `faultStatus` rises. After that, OFF and ON phases each last FAIL_HALF*TICK_DIV cycles for as long as the flag stays set at diagnosis.
- R5: In failure-rate mode, an `underloadFlag` of 0 at the diagnosis tick clears `faultStatus`. That ON phase is extended to NORM_HALF*TICK_DIV cycles, and the normal rate resumes.
- R6: A `shortFlag` of 1 at the diagnosis tick drops the drive at that tick and latches it off with `faultStatus` at 1 until the selector is released.
- R7: During an ON phase, `overTempFlag` or `shortFlag` turns the drive off on the next edge and keeps it off while either flag stays high, with `faultStatus` unchanged. Once both flags are clear inside the retry window, the drive is back on at the next edge and a full ON phase is timed from that edge.
- R8: If a protective trip is still present, or recurs, once RETRY_TICKS ticks have passed since the first trip of the ON phase, the drive latches off with `faultStatus` at 1. Clearing the flags has no effect on the latch. Release followed by a new selector closing runs a normal initialisation again.
- R9: Any values on the three flags during an OFF phase have no effect on the OFF duration or on `faultStatus`.
- R10: `underloadFlag` raised during an ON phase after the diagnosis tick is ignored: the phase keeps its full length and `faultStatus` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selEngaged | input | 1 | 1 while the selector holds the output low (indicator requested) |
| underloadFlag | input | 1 | 1 when load current is below the underload threshold |
| shortFlag | input | 1 | 1 when the power stage reports current limiting or a short |
| overTempFlag | input | 1 | 1 when the power stage reports overtemperature |
| lampDrive | output | 1 | Lamp-drive enable |
| faultStatus | output | 1 | 1 in failure-rate mode or in the latched-off state |

## Verification
A wrong rate-mode bit appears at the ports as the wrong ON or OFF width within one half-period of the event that set it. The ON phase is also cut at DIAG_TICKS when it should run to full length, and `faultStatus` disagrees with the expected value immediately after the diagnosis tick. A phase or window counter that is off by one tick shifts a measured edge by exactly TICK_DIV cycles, so the bench compares edge-to-edge widths exactly. A lost latch appears as the drive returning within a few cycles of the protection flags clearing. A sticky latch or sticky mode bit appears one cycle after a selector release, as a drive or fault output that should be 0.

// File: rtl/flasher_pkg.sv
package flasher_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INIT  = 3'd1,
    ST_ON    = 3'd2,
    ST_OFF   = 3'd3,
    ST_PROT  = 3'd4,
    ST_LATCH = 3'd5
  } flashState_t;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic phaseClr;   // restart the phase counter
    logic useFail;    // half-period compare uses the failure reload
    logic windowClr;  // restart the retry window
    logic windowRun;  // retry window counts ticks
  } ctlStrobe_t;

  // Events reported by the timing datapath
  typedef struct packed {
    logic initDone;
    logic diagNow;
    logic halfDone;
    logic windowDone;
  } timeStat_t;

endpackage

// File: rtl/flasher_timebase.sv
module flasher_timebase
  import flasher_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int INIT_TICKS  = 30,
  parameter int NORM_HALF   = 353,
  parameter int FAIL_HALF   = 159,
  parameter int DIAG_TICKS  = 130,
  parameter int RETRY_TICKS = 130
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output timeStat_t  stat
);

  localparam int PH_MAX = (INIT_TICKS > NORM_HALF) ? INIT_TICKS : NORM_HALF;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int WIN_W  = $clog2(RETRY_TICKS + 1);

  localparam logic [PH_W-1:0]  INIT_LAST = PH_W'(INIT_TICKS - 1);
  localparam logic [PH_W-1:0]  NORM_LAST = PH_W'(NORM_HALF - 1);
  localparam logic [PH_W-1:0]  FAIL_LAST = PH_W'(FAIL_HALF - 1);
  localparam logic [PH_W-1:0]  DIAG_LAST = PH_W'(DIAG_TICKS - 1);
  localparam logic [PH_W-1:0]  PH_TOP    = PH_W'(PH_MAX);
  localparam logic [WIN_W-1:0] WIN_TOP   = WIN_W'(RETRY_TICKS);

  logic tick;

  // Tick prescaler; a divide-by-one build ticks every cycle
  generate
    if (TICK_DIV > 1) begin : g_div
      localparam int PS_W = $clog2(TICK_DIV);
      localparam logic [PS_W-1:0] PS_LAST = PS_W'(TICK_DIV - 1);
      logic [PS_W-1:0] preCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 preCnt <= '0;
        else if (preCnt == PS_LAST) preCnt <= '0;
        else                       preCnt <= preCnt + 1'b1;
      end
      assign tick = (preCnt == PS_LAST);

      a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rstN)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  // Elapsed ticks in the current phase (saturating)
  logic [PH_W-1:0] elapsedCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              elapsedCnt <= '0;
    else if (ctl.phaseClr)                  elapsedCnt <= '0;
    else if (tick && elapsedCnt != PH_TOP)  elapsedCnt <= elapsedCnt + 1'b1;
  end

  // Ticks since the first protective trip of this ON phase
  logic [WIN_W-1:0] windowCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            windowCnt <= '0;
    else if (ctl.windowClr)                               windowCnt <= '0;
    else if (ctl.windowRun && tick && windowCnt != WIN_TOP) windowCnt <= windowCnt + 1'b1;
  end

  always_comb begin
    stat.initDone   = tick && (elapsedCnt == INIT_LAST);
    stat.diagNow    = tick && (elapsedCnt == DIAG_LAST);
    stat.halfDone   = tick && (elapsedCnt == (ctl.useFail ? FAIL_LAST : NORM_LAST));
    stat.windowDone = (windowCnt == WIN_TOP);
  end

  a_r3_phase_bound: assert property (@(posedge clk) disable iff (!rstN)
    elapsedCnt <= PH_TOP);

  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rstN)
    windowCnt <= WIN_TOP);

  a_r8_window_restart: assert property (@(posedge clk) disable iff (!rstN)
    ctl.windowClr |=> windowCnt == '0);

endmodule

// File: rtl/flasher_ctrl.sv
module flasher_ctrl
  import flasher_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selEngaged,
  input  logic       underloadFlag,
  input  logic       shortFlag,
  input  logic       overTempFlag,
  input  timeStat_t  stat,
  output ctlStrobe_t ctl,
  output logic       lampDrive,
  output logic       faultStatus
);

  flashState_t state, nxtState;
  logic failMode, nxtFail;
  logic armed, nxtArmed;
  logic tripNow;

  assign tripNow = shortFlag || overTempFlag;

  always_comb begin
    nxtState      = state;
    nxtFail       = failMode;
    nxtArmed      = armed;
    ctl.phaseClr  = 1'b0;
    ctl.windowClr = 1'b0;
    ctl.windowRun = armed;
    ctl.useFail   = failMode;

    if (!selEngaged) begin
      nxtState = ST_IDLE;
      nxtFail  = 1'b0;
      nxtArmed = 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          nxtState     = ST_INIT;
          ctl.phaseClr = 1'b1;
        end
        ST_INIT: begin
          if (stat.initDone) begin
            nxtState     = ST_ON;
            ctl.phaseClr = 1'b1;
          end
        end
        ST_ON: begin
          if (stat.diagNow && shortFlag) begin
            nxtState = ST_LATCH;
          end else if (tripNow) begin
            if (armed && stat.windowDone) begin
              nxtState = ST_LATCH;
            end else begin
              nxtState = ST_PROT;
              if (!armed) begin
                nxtArmed      = 1'b1;
                ctl.windowClr = 1'b1;
              end
            end
          end else if (stat.diagNow && !failMode && underloadFlag) begin
            nxtState     = ST_OFF;
            nxtFail      = 1'b1;
            ctl.phaseClr = 1'b1;
          end else if (stat.diagNow && failMode && !underloadFlag) begin
            nxtFail = 1'b0;
          end else if (stat.halfDone) begin
            nxtState     = ST_OFF;
            nxtArmed     = 1'b0;
            ctl.phaseClr = 1'b1;
          end
        end
        ST_PROT: begin
          if (stat.windowDone) begin
            nxtState = ST_LATCH;
          end else if (!tripNow) begin
            nxtState     = ST_ON;
            ctl.phaseClr = 1'b1;
          end
        end
        ST_OFF: begin
          if (stat.halfDone) begin
            nxtState     = ST_ON;
            ctl.phaseClr = 1'b1;
          end
        end
        ST_LATCH: nxtState = ST_LATCH;
        default:  nxtState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      failMode <= 1'b0;
      armed    <= 1'b0;
    end else begin
      state    <= nxtState;
      failMode <= nxtFail;
      armed    <= nxtArmed;
    end
  end

  assign lampDrive   = (state == ST_ON);
  assign faultStatus = failMode || (state == ST_LATCH);

  a_r1_release_off: assert property (@(posedge clk) disable iff (!rstN)
    !selEngaged |=> !lampDrive && !faultStatus);

  a_r2_rise_needs_sel: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lampDrive) |-> $past(selEngaged));

  a_r7_trip_off: assert property (@(posedge clk) disable iff (!rstN)
    lampDrive && tripNow |=> !lampDrive);

  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LATCH) && selEngaged |=> (state == ST_LATCH) && !lampDrive && faultStatus);

  a_r5_fault_clear_src: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultStatus) |-> $past(!selEngaged) || $past(state == ST_ON));

  a_r9_off_no_fault: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_OFF) && selEngaged |=> $stable(faultStatus));

endmodule

// File: rtl/turn_flasher.sv
module turn_flasher
  import flasher_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int INIT_TICKS  = 30,
  parameter int NORM_HALF   = 353,
  parameter int FAIL_HALF   = 159,
  parameter int DIAG_TICKS  = 130,
  parameter int RETRY_TICKS = 130
) (
  input  logic clk,
  input  logic rstN,
  input  logic selEngaged,
  input  logic underloadFlag,
  input  logic shortFlag,
  input  logic overTempFlag,
  output logic lampDrive,
  output logic faultStatus
);

  ctlStrobe_t ctl;
  timeStat_t  stat;

  flasher_timebase #(
    .TICK_DIV(TICK_DIV), .INIT_TICKS(INIT_TICKS), .NORM_HALF(NORM_HALF),
    .FAIL_HALF(FAIL_HALF), .DIAG_TICKS(DIAG_TICKS), .RETRY_TICKS(RETRY_TICKS)
  ) u_timebase (
    .clk(clk), .rstN(rstN), .ctl(ctl), .stat(stat)
  );

  flasher_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .selEngaged(selEngaged), .underloadFlag(underloadFlag),
    .shortFlag(shortFlag), .overTempFlag(overTempFlag),
    .stat(stat), .ctl(ctl),
    .lampDrive(lampDrive), .faultStatus(faultStatus)
  );

endmodule

// File: tb/turn_flasher_tb.sv
module turn_flasher_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int INIT  = 5;
  localparam int NORM  = 20;
  localparam int FAILH = 9;
  localparam int DIAG  = 4;
  localparam int RETRY = 15;

  logic clk = 1'b0, rstN = 1'b0;
  logic sel = 1'b0, ul = 1'b0, sc = 1'b0, ot = 1'b0;
  logic drive, fault;

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nChecks = 0, nFail = 0;

  turn_flasher #(
    .TICK_DIV(DIV), .INIT_TICKS(INIT), .NORM_HALF(NORM),
    .FAIL_HALF(FAILH), .DIAG_TICKS(DIAG), .RETRY_TICKS(RETRY)
  ) u_dut (
    .clk(clk), .rstN(rstN), .selEngaged(sel), .underloadFlag(ul),
    .shortFlag(sc), .overTempFlag(ot), .lampDrive(drive), .faultStatus(fault)
  );

  function automatic int halfCycles(input bit failRate);
    return (failRate ? FAILH : NORM) * DIV;
  endfunction
  function automatic int diagCycles();
    return DIAG * DIV;
  endfunction
  function automatic int initMin();
    return (INIT - 1) * DIV + 2;
  endfunction
  function automatic int initMax();
    return INIT * DIV + 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic waitDrive(input logic lvl, input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (drive === lvl) begin
        at = cyc;
        return;
      end
    end
    nChecks++;
    nFail++;
    $display("FAIL timeout waiting for drive=%0d: actual %0d expected %0d", lvl, drive, lvl);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog expired: actual %0d expected %0d", cyc, 0);
    finishRun();
  end

  initial begin
    int tOn, tOff, tNext, t0, n;
    int unsigned seedInit;
    seedInit = $urandom(32'h5EED_1234);

    repeat (3) @(negedge clk);
    check(drive == 1'b0, "R1", "drive in reset", drive, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(drive == 1'b0 && fault == 1'b0, "R1", "idle outputs", {drive, fault}, 0);

    // R2: initialisation delay
    sel = 1'b1; t0 = cyc;
    waitDrive(1'b1, 200, tOn);
    check(tOn - t0 >= initMin() && tOn - t0 <= initMax(), "R2", "init delay",
          tOn - t0, initMax());

    // R3: normal rate
    waitDrive(1'b0, 500, tOff);
    check(tOff - tOn == halfCycles(0), "R3", "normal ON width", tOff - tOn, halfCycles(0));

    // R9: random flag noise during OFF phases
    for (int k = 0; k < 5; k++) begin
      n = $urandom_range(halfCycles(0) - 6, 1);
      for (int j = 0; j < n; j++) begin
        {ul, sc, ot} = 3'($urandom);
        @(negedge clk);
      end
      {ul, sc, ot} = 3'b000;
      check(fault == 1'b0, "R9", "fault after OFF noise", fault, 0);
      waitDrive(1'b1, 500, tNext);
      check(tNext - tOff == halfCycles(0), "R9", "OFF width under noise", tNext - tOff, halfCycles(0));
      tOn = tNext;
      waitDrive(1'b0, 500, tOff);
      check(tOff - tOn == halfCycles(0), "R3", "normal ON width", tOff - tOn, halfCycles(0));
    end

    // R10: underload after the diagnosis tick is ignored
    waitDrive(1'b1, 500, tOn);
    repeat (diagCycles() + DIV) @(negedge clk);
    ul = 1'b1;
    waitDrive(1'b0, 500, tOff);
    ul = 1'b0;
    check(tOff - tOn == halfCycles(0), "R10", "late underload ON width", tOff - tOn, halfCycles(0));
    check(fault == 1'b0, "R10", "late underload fault", fault, 0);

    // R4: underload at diagnosis
    waitDrive(1'b1, 500, tOn);
    ul = 1'b1;
    waitDrive(1'b0, 500, tOff);
    check(tOff - tOn == diagCycles(), "R4", "cut ON width", tOff - tOn, diagCycles());
    check(fault == 1'b1, "R4", "fault after underload", fault, 1);
    waitDrive(1'b1, 500, tOn);
    check(tOn - tOff == halfCycles(1), "R4", "failure OFF width", tOn - tOff, halfCycles(1));
    waitDrive(1'b0, 500, tOff);
    check(tOff - tOn == halfCycles(1), "R4", "failure ON width", tOff - tOn, halfCycles(1));
    ul = 1'b0;

    // R5: repaired lamp
    waitDrive(1'b1, 500, tOn);
    check(tOn - tOff == halfCycles(1), "R5", "failure OFF before repair", tOn - tOff, halfCycles(1));
    waitDrive(1'b0, 500, tOff);
    check(tOff - tOn == halfCycles(0), "R5", "repaired ON width", tOff - tOn, halfCycles(0));
    check(fault == 1'b0, "R5", "fault after repair", fault, 0);
    waitDrive(1'b1, 500, tOn);
    check(tOn - tOff == halfCycles(0), "R5", "normal OFF after repair", tOn - tOff, halfCycles(0));
    waitDrive(1'b0, 500, tOff);

    // R6: short exactly at the diagnosis tick
    waitDrive(1'b1, 500, tOn);
    repeat (diagCycles() - 1) @(negedge clk);
    sc = 1'b1;
    waitDrive(1'b0, 50, tOff);
    sc = 1'b0;
    check(tOff - tOn == diagCycles(), "R6", "ON width to short", tOff - tOn, diagCycles());
    repeat (3 * halfCycles(0)) @(negedge clk);
    check(drive == 1'b0, "R6", "latched drive", drive, 0);
    check(fault == 1'b1, "R6", "latched fault", fault, 1);

    // R1: release clears latch and fault
    sel = 1'b0;
    @(negedge clk);
    check(drive == 1'b0 && fault == 1'b0, "R1", "outputs after release", {drive, fault}, 0);
    repeat (3) @(negedge clk);

    // R7: brief overtemperature inside the window
    sel = 1'b1; t0 = cyc;
    waitDrive(1'b1, 200, tOn);
    check(tOn - t0 >= initMin() && tOn - t0 <= initMax(), "R2", "re-init delay",
          tOn - t0, initMax());
    repeat (3) @(negedge clk);
    ot = 1'b1;
    @(negedge clk);
    check(drive == 1'b0, "R7", "drive after trip", drive, 0);
    repeat (10) @(negedge clk);
    check(drive == 1'b0 && fault == 1'b0, "R7", "held off, no fault", {drive, fault}, 0);
    ot = 1'b0;
    @(negedge clk);
    check(drive == 1'b1, "R7", "restart after clear", drive, 1);
    tOn = cyc;
    waitDrive(1'b0, 500, tOff);
    check(tOff - tOn >= halfCycles(0) - DIV + 1 && tOff - tOn <= halfCycles(0), "R7",
          "restarted ON width", tOff - tOn, halfCycles(0));

    // R8: trip persists past the retry window
    waitDrive(1'b1, 500, tOn);
    repeat (2) @(negedge clk);
    ot = 1'b1;
    repeat (RETRY * DIV + 2 * DIV) @(negedge clk);
    check(drive == 1'b0 && fault == 1'b1, "R8", "latched after window", {drive, fault}, 1);
    ot = 1'b0;
    repeat (40) @(negedge clk);
    check(drive == 1'b0, "R8", "latch holds after clear", drive, 0);
    check(fault == 1'b1, "R8", "fault holds after clear", fault, 1);
    sel = 1'b0;
    @(negedge clk);
    check(fault == 1'b0, "R8", "fault after release", fault, 0);
    repeat (2) @(negedge clk);
    sel = 1'b1; t0 = cyc;
    waitDrive(1'b1, 200, tOn);
    check(tOn - t0 >= initMin() && tOn - t0 <= initMax(), "R8", "init after latch",
          tOn - t0, initMax());
    waitDrive(1'b0, 500, tOff);
    check(tOff - tOn == halfCycles(0), "R8", "normal ON after latch", tOff - tOn, halfCycles(0));

    finishRun();
  end

endmodule